// File: doc/BRIEF.md
# Test Access Port Controller with Identification, User-Code and Bypass Registers

This block is a boundary-test access port for a chip. It runs the sixteen-state test controller on the test clock. It also holds a 10-bit instruction register, and it decodes the current instruction to pick which data register sits between the serial input and the serial output. Three data registers are built in: a one-bit bypass stage, a 32-bit identification register and a 32-bit user-code register. Capture, shift and update strobes come out of the block, together with a one-hot user-select vector. External user registers use these to attach, and they return their serial bits on a small input bus.

The controller is cleared only by the asynchronous power-on reset or by walking it to the Test-Logic-Reset state. The device program input enters the block but has no effect on the controller. User instructions only take effect once the configured input is high. Before that, they behave as bypass.

Top module: `jtag_tap_top`

## Requirements
- R1: On each rising edge of `tck` the controller follows the standard sixteen-state test graph, driven by `tms`. For example, Test-Logic-Reset goes to Run-Test/Idle when `tms`=0, and Select-DR-Scan goes to Select-IR-Scan when `tms`=1.
- R2: From any state, five rising edges in a row with `tms`=1 put the controller in Test-Logic-Reset.
- R3: While in Test-Logic-Reset, the current instruction becomes IDCODE (opcode 10'h009). Scanned data then returns the identification value 32'h1A5C_E093.
- R4: In Capture-IR the instruction shift register loads a status word in place of an opcode. Bits [1:0]=2'b01, bit 2 equals `configured`, and the upper bits are 0. Bits are shifted out least significant bit first.
- R5: In Capture-DR the selected register is parallel-loaded. IDCODE loads 32'h1A5C_E093, USERCODE (10'h008) loads 32'h5EED_0C0D, and bypass loads 0. Data is shifted out least significant bit first, with `tdi` entering at the most significant end.
- R6: BYPASS (10'h3FF) and every opcode that is not decoded select the one-bit bypass register, so `tdo` repeats `tdi` one shift later.
- R7: While `configured`=0, the user opcodes USER1..USER4 (10'h002, 10'h003, 10'h022, 10'h023) select bypass and hold `sel_user` at 0.
- R8: While `configured`=1, opcode USERn sets only `sel_user[n-1]`, and in Shift-DR `tdo` carries `user_tdo[n-1]`.
- R9: `capture_dr`, `shift_dr` and `update_dr` are high exactly while the controller is in Capture-DR, Shift-DR and Update-DR respectively.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only for Shift-IR and Shift-DR.
- R11: `prog_n` has no effect on the controller state or on the current instruction.
- R12: Asserting `trst_n` low at any time puts the controller in Test-Logic-Reset and IDCODE, and drives `tdo_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| prog_n | input | 1 | Device program request; ignored by the controller |
| configured | input | 1 | High once the device is configured; enables user instructions |
| user_tdo | input | NUM_USER | Serial outputs of external user registers |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Output enable for tdo |
| capture_dr | output | 1 | Controller is in Capture-DR |
| shift_dr | output | 1 | Controller is in Shift-DR |
| update_dr | output | 1 | Controller is in Update-DR |
| sel_user | output | NUM_USER | One-hot select of the active user register |

## Verification
State, instruction and shift registers change on a rising edge of `tck`. The strobes and `sel_user` are decoded from them, so they are valid right after that edge. `tdo` and `tdo_en` reach the port only at the falling edge that follows. For this reason every directed step of the bench drives `tms` and `tdi` just after a falling edge, lets one rising edge pass, and samples all outputs one nanosecond after the next falling edge. Each sample therefore shows the state entered at that rising edge. The falling-edge timing of `tdo` itself is checked by sampling just after a rising edge in Shift-DR, where the old bit must still be present. A second sample is then taken after the falling edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET  = 4'd0,
      ST_IDLE   = 4'd1,
      ST_SEL_DR = 4'd2,
      ST_CAP_DR = 4'd3,
      ST_SH_DR  = 4'd4,
      ST_EX1_DR = 4'd5,
      ST_PAU_DR = 4'd6,
      ST_EX2_DR = 4'd7,
      ST_UPD_DR = 4'd8,
      ST_SEL_IR = 4'd9,
      ST_CAP_IR = 4'd10,
      ST_SH_IR  = 4'd11,
      ST_EX1_IR = 4'd12,
      ST_PAU_IR = 4'd13,
      ST_EX2_IR = 4'd14,
      ST_UPD_IR = 4'd15
   } tap_state_t;

   typedef enum logic [1:0] {
      DR_BYP  = 2'd0,
      DR_ID   = 2'd1,
      DR_UC   = 2'd2,
      DR_USER = 2'd3
   } dr_sel_t;

   function automatic tap_state_t tap_next(input tap_state_t cur, input logic m);
      tap_state_t nxt;
      case (cur)
         ST_RESET:  nxt = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
         default:   nxt = m ? ST_SEL_DR : ST_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
   import jtag_tap_pkg::*;
#(
   parameter int                       IR_W        = 10,
   parameter int                       NUM_USER    = 4,
   parameter logic [IR_W-1:0]          IDCODE_OP   = 10'h009,
   parameter logic [IR_W-1:0]          USERCODE_OP = 10'h008,
   parameter logic [NUM_USER*IR_W-1:0] USER_OPS    = {10'h023, 10'h022, 10'h003, 10'h002}
) (
   input  logic                tck,
   input  logic                trst_n,
   input  tap_state_t          state,
   input  logic                tdi,
   input  logic                configured,
   output logic [IR_W-1:0]     ir_sr,
   output logic [IR_W-1:0]     ir_q,
   output dr_sel_t             dr_sel,
   output logic [NUM_USER-1:0] sel_user
);

   localparam int STAT_PAD = IR_W - 3;

   logic [IR_W-1:0]     status_word;
   logic [NUM_USER-1:0] user_hit;

   assign status_word = {{STAT_PAD{1'b0}}, configured, 2'b01};

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
      end else if (state == ST_CAP_IR) begin
         ir_sr <= status_word;
      end else if (state == ST_SH_IR) begin
         ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  ir_q <= IDCODE_OP;
      else if (state == ST_RESET)   ir_q <= IDCODE_OP;
      else if (state == ST_UPD_IR)  ir_q <= ir_sr;
   end

   for (genvar g = 0; g < NUM_USER; g++) begin : g_user_dec
      assign user_hit[g] = (ir_q == USER_OPS[g*IR_W +: IR_W]);
   end

   always_comb begin
      dr_sel   = DR_BYP;
      sel_user = '0;
      if (ir_q == IDCODE_OP) begin
         dr_sel = DR_ID;
      end else if (ir_q == USERCODE_OP) begin
         dr_sel = DR_UC;
      end else if (configured && (|user_hit)) begin
         dr_sel   = DR_USER;
         sel_user = user_hit;
      end
   end

endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
   import jtag_tap_pkg::*;
#(
   parameter int               DR_W   = 32,
   parameter logic [DR_W-1:0]  ID_VAL = 32'h1A5C_E093,
   parameter logic [DR_W-1:0]  UC_VAL = 32'h5EED_0C0D
) (
   input  logic    tck,
   input  logic    trst_n,
   input  logic    capture,
   input  logic    shift,
   input  logic    tdi,
   input  dr_sel_t dr_sel,
   output logic    byp_so,
   output logic    id_so,
   output logic    uc_so
);

   localparam logic [2*DR_W-1:0] CAP_VALS = {UC_VAL, ID_VAL};

   logic [1:0] wide_so;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                          byp_so <= 1'b0;
      else if (capture && dr_sel == DR_BYP) byp_so <= 1'b0;
      else if (shift && dr_sel == DR_BYP)   byp_so <= tdi;
   end

   for (genvar g = 0; g < 2; g++) begin : g_wide
      localparam dr_sel_t MY_SEL = (g == 0) ? DR_ID : DR_UC;
      logic [DR_W-1:0] sr;
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)                          sr <= '0;
         else if (capture && dr_sel == MY_SEL) sr <= CAP_VALS[g*DR_W +: DR_W];
         else if (shift && dr_sel == MY_SEL)   sr <= {tdi, sr[DR_W-1:1]};
      end
      assign wide_so[g] = sr[0];
   end

   assign id_so = wide_so[0];
   assign uc_so = wide_so[1];

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
   import jtag_tap_pkg::*;
#(
   parameter int                       IR_W        = 10,
   parameter int                       DR_W        = 32,
   parameter int                       NUM_USER    = 4,
   parameter logic [DR_W-1:0]          ID_VAL      = 32'h1A5C_E093,
   parameter logic [DR_W-1:0]          UC_VAL      = 32'h5EED_0C0D,
   parameter logic [IR_W-1:0]          IDCODE_OP   = 10'h009,
   parameter logic [IR_W-1:0]          USERCODE_OP = 10'h008,
   parameter logic [NUM_USER*IR_W-1:0] USER_OPS    = {10'h023, 10'h022, 10'h003, 10'h002}
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tms,
   input  logic                tdi,
   input  logic                prog_n,
   input  logic                configured,
   input  logic [NUM_USER-1:0] user_tdo,
   output logic                tdo,
   output logic                tdo_en,
   output logic                capture_dr,
   output logic                shift_dr,
   output logic                update_dr,
   output logic [NUM_USER-1:0] sel_user
);

   if (IR_W < 3) begin : g_bad_ir_w
      $error("IR_W must leave room for the status word");
   end
   if (NUM_USER < 1 || NUM_USER > 4) begin : g_bad_num_user
      $error("NUM_USER must be 1 to 4");
   end
   if (ID_VAL[0] != 1'b1) begin : g_bad_id
      $error("identification value must have bit 0 set");
   end

   tap_state_t      state;
   logic [IR_W-1:0] ir_sr;
   logic [IR_W-1:0] ir_q;
   dr_sel_t         dr_sel;
   logic            byp_so, id_so, uc_so;
   logic            dr_so, tdo_d;
   logic            unused_prog;
   logic            unused_ir_hi;

   assign unused_prog  = prog_n;
   assign unused_ir_hi = ^ir_sr[IR_W-1:1];

   jtag_tap_fsm u_fsm (
      .tck   (tck),
      .trst_n(trst_n),
      .tms   (tms),
      .state (state)
   );

   jtag_ir #(
      .IR_W       (IR_W),
      .NUM_USER   (NUM_USER),
      .IDCODE_OP  (IDCODE_OP),
      .USERCODE_OP(USERCODE_OP),
      .USER_OPS   (USER_OPS)
   ) u_ir (
      .tck       (tck),
      .trst_n    (trst_n),
      .state     (state),
      .tdi       (tdi),
      .configured(configured),
      .ir_sr     (ir_sr),
      .ir_q      (ir_q),
      .dr_sel    (dr_sel),
      .sel_user  (sel_user)
   );

   assign capture_dr = (state == ST_CAP_DR);
   assign shift_dr   = (state == ST_SH_DR);
   assign update_dr  = (state == ST_UPD_DR);

   jtag_dr_bank #(
      .DR_W  (DR_W),
      .ID_VAL(ID_VAL),
      .UC_VAL(UC_VAL)
   ) u_dr (
      .tck    (tck),
      .trst_n (trst_n),
      .capture(capture_dr),
      .shift  (shift_dr),
      .tdi    (tdi),
      .dr_sel (dr_sel),
      .byp_so (byp_so),
      .id_so  (id_so),
      .uc_so  (uc_so)
   );

   always_comb begin
      case (dr_sel)
         DR_ID:   dr_so = id_so;
         DR_UC:   dr_so = uc_so;
         DR_USER: dr_so = |(sel_user & user_tdo);
         default: dr_so = byp_so;
      endcase
   end

   always_comb begin
      if (state == ST_SH_IR)      tdo_d = ir_sr[0];
      else if (state == ST_SH_DR) tdo_d = dr_so;
      else                        tdo_d = 1'b0;
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= tdo_d;
         tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
      end
   end

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
   import jtag_tap_pkg::*;
#(
   parameter int              IR_W      = 10,
   parameter int              NUM_USER  = 4,
   parameter logic [IR_W-1:0] IDCODE_OP = 10'h009
) (
   input logic                tck,
   input logic                trst_n,
   input logic                tms,
   input logic                configured,
   input tap_state_t          state,
   input logic [IR_W-1:0]     ir_q,
   input logic [IR_W-1:0]     ir_sr,
   input logic [NUM_USER-1:0] sel_user,
   input logic                capture_dr,
   input logic                shift_dr,
   input logic                update_dr,
   input logic                tdo_en
);

   logic [2:0] ones_cnt;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            ones_cnt <= '0;
      else if (!tms)          ones_cnt <= '0;
      else if (ones_cnt != 5) ones_cnt <= ones_cnt + 3'd1;
   end

   p_tlr_exit_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET && !tms) |=> state == ST_IDLE);

   p_seldr_to_selir_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_SEL_DR && tms) |=> state == ST_SEL_IR);

   p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (tms && ones_cnt >= 3'd4) |=> state == ST_RESET);

   p_tlr_idcode_r3: assert property (@(posedge tck) disable iff (!trst_n)
      state == ST_RESET |=> ir_q == IDCODE_OP);

   p_cap_ir_status_r4: assert property (@(posedge tck) disable iff (!trst_n)
      state == ST_CAP_IR |=> ir_sr[1:0] == 2'b01);

   p_user_gate_r7: assert property (@(posedge tck) disable iff (!trst_n)
      !configured |-> sel_user == '0);

   p_user_onehot_r8: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(sel_user));

   p_capture_next_r9: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> (shift_dr || state == ST_EX1_DR));

   p_update_entry_r9: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(update_dr) |-> ($past(state) == ST_EX1_DR || $past(state) == ST_EX2_DR));

   p_en_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind jtag_tap_top jtag_tap_chk #(
   .IR_W     (IR_W),
   .NUM_USER (NUM_USER),
   .IDCODE_OP(IDCODE_OP)
) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tms       (tms),
   .configured(configured),
   .state     (state),
   .ir_q      (ir_q),
   .ir_sr     (ir_sr),
   .sel_user  (sel_user),
   .capture_dr(capture_dr),
   .shift_dr  (shift_dr),
   .update_dr (update_dr),
   .tdo_en    (tdo_en)
);

// File: tb/jtag_tap_top_tb.sv
`timescale 1ns/1ps
module jtag_tap_top_tb;

   localparam logic [31:0] EXP_ID = 32'h1A5C_E093;
   localparam logic [31:0] EXP_UC = 32'h5EED_0C0D;
   localparam logic [9:0]  OP_ID  = 10'h009;
   localparam logic [9:0]  OP_UC  = 10'h008;
   localparam logic [9:0]  OP_BYP = 10'h3FF;
   localparam logic [9:0]  OP_U1  = 10'h002;
   localparam logic [9:0]  OP_U2  = 10'h003;
   localparam logic [9:0]  OP_U3  = 10'h022;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       tms = 1'b1;
   logic       tdi = 1'b0;
   logic       prog_n = 1'b1;
   logic       configured = 1'b0;
   logic [3:0] user_tdo = 4'b0000;
   logic       tdo, tdo_en, capture_dr, shift_dr, update_dr;
   logic [3:0] sel_user;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 tck = ~tck;

   jtag_tap_top u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .prog_n(prog_n),
      .configured(configured), .user_tdo(user_tdo), .tdo(tdo), .tdo_en(tdo_en),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .sel_user(sel_user)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic shift_body(input int n, input logic [63:0] din, output logic [63:0] dout);
      dout = '0;
      step(1'b0, 1'b0);
      dout[0] = tdo;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         if (i < n - 1) dout[i+1] = tdo;
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      shift_body(n, din, dout);
   endtask

   task automatic scan_ir(input logic [9:0] op, output logic [63:0] dout);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      shift_body(10, {54'd0, op}, dout);
   endtask

   task automatic t_reset();
      logic [63:0] d;
      chk("R12 tdo_en after reset", tdo_en, 0);
      chk("R9 strobes after reset", {capture_dr, shift_dr, update_dr}, 0);
      chk("R7 sel_user after reset", sel_user, 0);
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, d);
      chk("R3 R5 idcode after reset", d[31:0], EXP_ID);
   endtask

   task automatic t_ir_capture();
      logic [63:0] d;
      configured = 1'b0;
      scan_ir(OP_BYP, d);
      chk("R4 status unconfigured", d[9:0], 10'h001);
      configured = 1'b1;
      scan_ir(OP_BYP, d);
      chk("R4 status configured", d[9:0], 10'h005);
      configured = 1'b0;
   endtask

   task automatic t_bypass();
      logic [63:0] d;
      scan_ir(OP_BYP, d);
      scan_dr(9, 64'h0A5, d);
      chk("R6 bypass delay", d[8:0], 9'h14A);
      scan_ir(10'h155, d);
      scan_dr(9, 64'h0C3, d);
      chk("R6 undecoded opcode acts as bypass", d[8:0], 9'h186);
   endtask

   task automatic t_usercode();
      logic [63:0] d;
      scan_ir(OP_UC, d);
      scan_dr(32, 64'h0, d);
      chk("R5 usercode capture", d[31:0], EXP_UC);
      scan_ir(OP_ID, d);
      scan_dr(32, 64'hFFFF_FFFF, d);
      chk("R5 idcode capture", d[31:0], EXP_ID);
   endtask

   task automatic t_user();
      logic [63:0] d;
      configured = 1'b0;
      user_tdo = 4'b1111;
      scan_ir(OP_U2, d);
      chk("R7 sel_user gated", sel_user, 0);
      scan_dr(4, 64'h0, d);
      chk("R7 user op acts as bypass", d[3:0], 4'h0);
      configured = 1'b1;
      user_tdo = 4'b0100;
      scan_ir(OP_U3, d);
      chk("R8 USER3 select", sel_user, 4'b0100);
      scan_dr(4, 64'h0, d);
      chk("R8 USER3 data routed", d[3:0], 4'hF);
      scan_ir(OP_U1, d);
      chk("R8 USER1 select", sel_user, 4'b0001);
      scan_dr(4, 64'h0, d);
      chk("R8 USER1 data routed", d[3:0], 4'h0);
      configured = 1'b0;
      #1;
      chk("R7 deconfigure drops select", sel_user, 0);
      user_tdo = 4'b0000;
   endtask

   task automatic t_strobes();
      step(1'b1, 1'b0);
      chk("R9 select-dr no strobes", {capture_dr, shift_dr, update_dr}, 0);
      step(1'b0, 1'b0);
      chk("R9 capture strobe", {capture_dr, shift_dr, update_dr}, 3'b100);
      step(1'b0, 1'b0);
      chk("R9 shift strobe", {capture_dr, shift_dr, update_dr}, 3'b010);
      chk("R10 enable in shift", tdo_en, 1);
      step(1'b1, 1'b0);
      chk("R10 enable off in exit1", tdo_en, 0);
      step(1'b0, 1'b0);
      chk("R9 pause no strobes", {capture_dr, shift_dr, update_dr}, 0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      chk("R1 R9 update strobe via pause path", {capture_dr, shift_dr, update_dr}, 3'b001);
      step(1'b0, 1'b0);
   endtask

   task automatic t_tdo_edge();
      logic [63:0] d;
      scan_ir(OP_BYP, d);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R6 bypass captured zero", tdo, 0);
      tms = 1'b0;
      tdi = 1'b1;
      @(posedge tck);
      #1;
      chk("R10 tdo holds after rising edge", tdo, 0);
      @(negedge tck);
      #1;
      chk("R10 tdo updates on falling edge", tdo, 1);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic t_five_ones();
      logic [63:0] d;
      scan_ir(OP_BYP, d);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      chk("R2 reset state no strobes", {capture_dr, shift_dr, update_dr, tdo_en}, 0);
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, d);
      chk("R2 R3 five ones restore idcode", d[31:0], EXP_ID);
      scan_ir(OP_UC, d);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, d);
      chk("R2 five ones from shift-dr", d[31:0], EXP_ID);
   endtask

   task automatic t_prog();
      logic [63:0] d;
      scan_ir(OP_UC, d);
      prog_n = 1'b0;
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
      scan_dr(32, 64'h0, d);
      prog_n = 1'b1;
      chk("R11 program pin ignored", d[31:0], EXP_UC);
   endtask

   task automatic t_trst();
      logic [63:0] d;
      scan_ir(OP_UC, d);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      trst_n = 1'b0;
      #2;
      chk("R12 async reset clears enable", tdo_en, 0);
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      @(negedge tck);
      #1;
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, d);
      chk("R12 async reset restores idcode", d[31:0], EXP_ID);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #18;
      trst_n = 1'b1;
      @(negedge tck);
      #1;
      t_reset();
      t_ir_capture();
      t_bypass();
      t_usercode();
      t_user();
      t_strobes();
      t_tdo_edge();
      t_five_ones();
      t_prog();
      t_trst();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule